// File: doc/BRIEF.md
# Page-Table Entry Status-Bit Updater

This block works beside a hierarchical page-table walker. Each time the walker fetches a paging-structure entry during a translation, it hands the entry to this block together with the entry's memory address, its level, whether the entry maps the final page, and whether the access is a read or a write. The block decides whether the entry's status bits need updating. Bit 5 marks that the entry was used. Bit 6 marks that the mapped page was written. When an update is needed, the block writes the entry back to memory with those bits set.

The write-back is an atomic read-modify-write. The block re-reads the entry under a memory lock, ORs in the required bits, and writes the result while the lock is still held. A change that software makes to the entry in memory between the walker's fetch and the update is therefore kept. The block never clears a status bit. When a three-level extended-address mode is active, the top-level pointer entries are outside the update rules. A missing pointer entry in that mode is reported on a separate general-protection output. Only one update is handled at a time.

Top module: `pte_flag_updater`

## Requirements
- R1: For a present entry that is not an excluded pointer entry and has bit 5 (bit 0 is the present bit) clear, the block issues a write-back, and the written word has bit 5 set.
- R2: For a write access to an entry marked as mapping the final page (`req_leaf`=1), a write-back is issued if bit 5 or bit 6 is clear, and the written word has both bit 5 and bit 6 set.
- R3: For an entry with `req_leaf`=0, bit 6 of the written word equals bit 6 of the re-read word, even on a write access.
- R4: When every bit the access needs is already set, or no update applies, the block issues no memory request and raises `done` in the cycle after the request is accepted.
- R5: The written word is the re-read memory word ORed with the required bits. No bit that is set in the re-read word is ever cleared, and any other bits changed concurrently in memory are kept.
- R6: With `req_three_lvl`=1 and `req_level`=2, the entry is never updated. If its bit 0 is clear, `gp_fault` is high together with `done`; otherwise `gp_fault` stays low. With `req_three_lvl`=0, level-2 entries follow R1 and R2.
- R7: An entry whose bit 0 is clear (other than a pointer entry covered by R6) gets no update and no `gp_fault`.
- R8: A write-back is exactly one locked read, followed by exactly one locked write to `req_addr`. `mem_lock` is high during both. A request holds its address and direction until `mem_ack`. `req_ready` stays low from acceptance until `done`.
- R9: `done_entry` equals the written word when an update happened, and `req_entry` otherwise. `done` pulses for one cycle after the write is acknowledged.
- R10: After reset, `req_ready`=1, `mem_req`=0, `done`=0 and `gp_fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walker presents an entry |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | AW | Memory address of the entry |
| req_entry | input | 64 | Entry as fetched by the walker |
| req_level | input | 2 | Walk level, 0 = last level |
| req_leaf | input | 1 | Entry maps the final page |
| req_write | input | 1 | Access is a write |
| req_three_lvl | input | 1 | Three-level extended-address mode active |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Request is part of a locked read-modify-write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| done_entry | output | 64 | Resulting entry value |
| gp_fault | output | 1 | Missing pointer entry in three-level mode |

## Verification
The bench targets the following corner cases:

- Entries whose bits are already set. A design that rewrites them anyway shows up as an unexpected memory write or late completion.
- Directory entries hit by write accesses. A design that marks them dirty corrupts bit 6.
- Memory words that changed between fetch and update. A design that merges into the stale fetched copy loses the concurrent change, or clears a status bit.
- Level-2 entries with the three-level mode both on and off, with the present bit in both states. A design that mishandles them either updates excluded entries or reports the wrong fault.

The bench also checks the lock, the address and the read-before-write order on every memory access, and it varies the acknowledge delay.

// File: rtl/pte_upd_pkg.sv
`timescale 1ns/1ps
package pte_upd_pkg;

    localparam int ENTRY_W     = 64;
    localparam int LVL_W       = 2;
    localparam int PRESENT_BIT = 0;
    localparam int ACC_BIT     = 5;
    localparam int DIRTY_BIT   = 6;
    localparam logic [LVL_W-1:0] PTR_LEVEL = LVL_W'(2);

    typedef logic [ENTRY_W-1:0] entry_t;
    typedef logic [LVL_W-1:0]   level_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK_RD,
        ST_MODIFY,
        ST_WRITE,
        ST_DONE
    } upd_state_e;

    // Decision taken for one fetched entry
    typedef struct packed {
        logic used;       // entry takes part in translation
        logic dirty_tgt;  // entry maps the final page of a write
        logic gp;         // missing pointer entry in three-level mode
    } upd_plan_t;

    // Bits that the write-back must OR into the re-read word
    function automatic entry_t plan_mask(upd_plan_t p);
        entry_t m;
        m = '0;
        m[ACC_BIT]   = p.used;
        m[DIRTY_BIT] = p.used & p.dirty_tgt;
        return m;
    endfunction

endpackage

// File: rtl/pte_upd_decide.sv
`timescale 1ns/1ps
module pte_upd_decide
    import pte_upd_pkg::*;
(
    input  entry_t    entry,
    input  level_t    level,
    input  logic      leaf,
    input  logic      is_write,
    input  logic      three_lvl,
    output upd_plan_t plan,
    output logic      need_wb
);

    logic is_ptr;
    logic present;

    always_comb begin
        is_ptr         = three_lvl && (level == PTR_LEVEL);
        present        = entry[PRESENT_BIT];
        plan.used      = present && !is_ptr;
        plan.dirty_tgt = leaf && is_write;
        plan.gp        = is_ptr && !present;
        need_wb        = plan.used &&
                         (!entry[ACC_BIT] || (plan.dirty_tgt && !entry[DIRTY_BIT]));
    end

endmodule

// File: rtl/pte_upd_merge.sv
`timescale 1ns/1ps
module pte_upd_merge
    import pte_upd_pkg::*;
(
    input  entry_t rd_word,
    input  entry_t set_bits,
    output entry_t merged
);

    // Only ever sets bits: the re-read word is kept in full
    assign merged = rd_word | set_bits;

endmodule

// File: rtl/pte_upd_seq.sv
`timescale 1ns/1ps
module pte_upd_seq
    import pte_upd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  entry_t          req_entry,
    input  upd_plan_t       plan,
    input  logic            need_wb,
    input  entry_t          merged,
    input  logic            mem_ack,
    input  entry_t          mem_rdata,
    output logic            req_ready,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_lock,
    output logic [AW-1:0]   mem_addr,
    output entry_t          mem_wdata,
    output entry_t          rd_q,
    output entry_t          mask_q,
    output logic            done,
    output entry_t          done_entry,
    output logic            gp_fault
);

    upd_state_e      state_q, state_d;
    logic [AW-1:0]   addr_q;
    entry_t          wdata_q;
    entry_t          result_q;
    upd_plan_t       plan_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = need_wb ? ST_LOCK_RD : ST_DONE;
            ST_LOCK_RD: if (mem_ack)   state_d = ST_MODIFY;
            ST_MODIFY:                 state_d = ST_WRITE;
            ST_WRITE:   if (mem_ack)   state_d = ST_DONE;
            ST_DONE:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            rd_q     <= '0;
            wdata_q  <= '0;
            result_q <= '0;
            mask_q   <= '0;
            plan_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q   <= req_addr;
                    plan_q   <= plan;
                    mask_q   <= plan_mask(plan);
                    result_q <= req_entry;
                end
                ST_LOCK_RD: if (mem_ack) rd_q <= mem_rdata;
                ST_MODIFY:  wdata_q <= merged;
                ST_WRITE:   if (mem_ack) result_q <= wdata_q;
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_req    = (state_q == ST_LOCK_RD) || (state_q == ST_WRITE);
        mem_we     = (state_q == ST_WRITE);
        mem_lock   = mem_req;
        mem_addr   = addr_q;
        mem_wdata  = wdata_q;
        done       = (state_q == ST_DONE);
        done_entry = result_q;
        gp_fault   = done && plan_q.gp;
    end

    // ---------------- assertions ----------------
    p_acc_set_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[ACC_BIT]);

    p_leaf_dirty_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && plan_q.dirty_tgt) |-> mem_wdata[DIRTY_BIT]);

    p_nonleaf_dirty_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !plan_q.dirty_tgt) |-> (mem_wdata[DIRTY_BIT] == rd_q[DIRTY_BIT]));

    p_fast_done_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !need_wb) |=> (done && !mem_req));

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ((mem_wdata & rd_q) == rd_q));

    p_gp_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && plan.gp) |=> gp_fault);

    p_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_rd_then_wr_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack) |-> ##2 (mem_req && mem_we && mem_lock));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/pte_flag_updater.sv
`timescale 1ns/1ps
module pte_flag_updater
    import pte_upd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [AW-1:0]        req_addr,
    input  logic [ENTRY_W-1:0]   req_entry,
    input  logic [LVL_W-1:0]     req_level,
    input  logic                 req_leaf,
    input  logic                 req_write,
    input  logic                 req_three_lvl,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic                 mem_lock,
    output logic [AW-1:0]        mem_addr,
    output logic [ENTRY_W-1:0]   mem_wdata,
    input  logic                 mem_ack,
    input  logic [ENTRY_W-1:0]   mem_rdata,
    output logic                 done,
    output logic [ENTRY_W-1:0]   done_entry,
    output logic                 gp_fault
);

    upd_plan_t plan;
    logic      need_wb;
    entry_t    rd_q;
    entry_t    mask_q;
    entry_t    merged;

    pte_upd_decide u_decide (
        .entry     (req_entry),
        .level     (req_level),
        .leaf      (req_leaf),
        .is_write  (req_write),
        .three_lvl (req_three_lvl),
        .plan      (plan),
        .need_wb   (need_wb)
    );

    pte_upd_merge u_merge (
        .rd_word  (rd_q),
        .set_bits (mask_q),
        .merged   (merged)
    );

    pte_upd_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_entry  (req_entry),
        .plan       (plan),
        .need_wb    (need_wb),
        .merged     (merged),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .req_ready  (req_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_lock   (mem_lock),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rd_q       (rd_q),
        .mask_q     (mask_q),
        .done       (done),
        .done_entry (done_entry),
        .gp_fault   (gp_fault)
    );

    // Pointer entries of the three-level mode never reach memory
    p_ptr_untouched_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_three_lvl && req_level == PTR_LEVEL) |=> !mem_req);

    // A missing entry outside pointer level is neither updated nor faulted
    p_absent_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_entry[PRESENT_BIT] &&
         !(req_three_lvl && req_level == PTR_LEVEL)) |=> (done && !gp_fault && !mem_req));

endmodule

// File: tb/pte_flag_updater_bench.sv
`timescale 1ns/1ps
module pte_flag_updater_bench;

    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [AW-1:0] req_addr;
    logic [63:0] req_entry;
    logic [1:0]  req_level;
    logic        req_leaf, req_write, req_three_lvl;
    logic        mem_req, mem_we, mem_lock;
    logic [AW-1:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack;
    logic [63:0] mem_rdata;
    logic        done;
    logic [63:0] done_entry;
    logic        gp_fault;

    int checks = 0;
    int failures = 0;

    // bench memory model state
    logic [63:0] bmem [16];
    int reads, writes, lock_bad, addr_bad, order_bad, ready_bad;
    logic [AW-1:0] exp_addr;
    logic in_txn;

    always #2.5 clk = ~clk;

    pte_flag_updater #(.AW(AW)) u_pte_flag_updater (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_entry(req_entry), .req_level(req_level),
        .req_leaf(req_leaf), .req_write(req_write), .req_three_lvl(req_three_lvl),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .done_entry(done_entry), .gp_fault(gp_fault)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder with random acknowledge delay
    initial begin : responder
        int wcnt;
        logic armed;
        mem_ack = 1'b0; mem_rdata = '0; wcnt = 0; armed = 1'b0;
        forever begin
            @(negedge clk);
            if (in_txn && req_ready) ready_bad++;
            if (mem_ack) begin
                mem_ack = 1'b0;
                armed = 1'b0;
            end else if (mem_req) begin
                if (!mem_lock) lock_bad++;
                if (mem_addr != exp_addr) addr_bad++;
                if (!armed) begin armed = 1'b1; wcnt = $urandom_range(0, 3); end
                if (wcnt == 0) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        if (reads == 0) order_bad++;
                        bmem[mem_addr[3:0]] = mem_wdata;
                        writes++;
                    end else begin
                        if (writes != 0) order_bad++;
                        mem_rdata = bmem[mem_addr[3:0]];
                        reads++;
                    end
                end else begin
                    wcnt--;
                end
            end
        end
    end

    // One walker request. memval is the memory word at update time,
    // which may differ from the fetched entry (concurrent change).
    task automatic txn(input logic [AW-1:0] addr, input logic [63:0] entry,
                       input logic [63:0] memval, input logic [1:0] level,
                       input logic leaf, input logic wr, input logic tl, input string tag);
        logic is_ptr, present, used, need, gp;
        logic [63:0] mask, exp_res, exp_mem;
        int lat;
        is_ptr  = tl && (level == 2'd2);
        present = entry[0];
        used    = present && !is_ptr;
        mask    = '0;
        mask[5] = used;
        mask[6] = used && leaf && wr;
        need    = used && (!entry[5] || (leaf && wr && !entry[6]));
        gp      = is_ptr && !present;
        exp_res = need ? (memval | mask) : entry;
        exp_mem = need ? (memval | mask) : memval;

        bmem[addr[3:0]] = memval;
        reads = 0; writes = 0; lock_bad = 0; addr_bad = 0; order_bad = 0; ready_bad = 0;
        exp_addr = addr;
        req_addr = addr; req_entry = entry; req_level = level;
        req_leaf = leaf; req_write = wr; req_three_lvl = tl;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        in_txn = 1'b1;
        lat = 1;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        in_txn = 1'b0;
        chk(done, {tag, " R9 done seen"}, 64'(done), 64'd1);
        chk(done_entry == exp_res, {tag, " R9/R5 done_entry"}, done_entry, exp_res);
        chk(gp_fault == gp, {tag, " R6 gp_fault"}, 64'(gp_fault), 64'(gp));
        chk(writes == (need ? 1 : 0), {tag, " R4/R8 write count"}, 64'(writes), 64'(need ? 1 : 0));
        chk(reads == (need ? 1 : 0), {tag, " R8 read count"}, 64'(reads), 64'(need ? 1 : 0));
        chk(bmem[addr[3:0]] == exp_mem, {tag, " R5 memory word"}, bmem[addr[3:0]], exp_mem);
        if (!need)
            chk(lat == 1, {tag, " R4 one-cycle latency"}, 64'(lat), 64'd1);
        chk((lock_bad + addr_bad + order_bad + ready_bad) == 0, {tag, " R8 handshake"},
            64'(lock_bad + addr_bad + order_bad + ready_bad), 64'd0);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        in_txn = 1'b0;
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_entry = '0;
        req_level = '0; req_leaf = 1'b0; req_write = 1'b0; req_three_lvl = 1'b0;
        exp_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready && !mem_req && !done && !gp_fault, "R10 reset outputs",
            {60'd0, req_ready, mem_req, done, gp_fault}, 64'h8);

        // R1: leaf read, accessed clear
        txn(32'h1000_0001, 64'h0000_0000_0000_1003, 64'h0000_0000_0000_1003, 2'd0, 1'b1, 1'b0, 1'b0, "R1 leaf read");
        // R1: directory read, accessed clear
        txn(32'h1000_0002, 64'h0000_0000_0000_2001, 64'h0000_0000_0000_2001, 2'd1, 1'b0, 1'b0, 1'b0, "R1 dir read");
        // R2: leaf write, both clear
        txn(32'h1000_0003, 64'h0000_0000_0000_3007, 64'h0000_0000_0000_3007, 2'd0, 1'b1, 1'b1, 1'b0, "R2 leaf write");
        // R2: large-page directory leaf write, accessed already set
        txn(32'h1000_0004, 64'h0000_0000_0040_00A1, 64'h0000_0000_0040_00A1, 2'd1, 1'b1, 1'b1, 1'b0, "R2 large page");
        // R3: directory write, dirty clear stays clear
        txn(32'h1000_0005, 64'h0000_0000_0000_5001, 64'h0000_0000_0000_5001, 2'd1, 1'b0, 1'b1, 1'b0, "R3 dir write clear");
        // R3: directory write, bit 6 set in memory stays set
        txn(32'h1000_0006, 64'h0000_0000_0000_6041, 64'h0000_0000_0000_6041, 2'd2, 1'b0, 1'b1, 1'b0, "R3 dir write set");
        // R4: everything already set
        txn(32'h1000_0007, 64'h0000_0000_0000_7021, 64'h0000_0000_0000_7021, 2'd0, 1'b1, 1'b0, 1'b0, "R4 read set");
        txn(32'h1000_0008, 64'h0000_0000_0000_8061, 64'h0000_0000_0000_8061, 2'd0, 1'b1, 1'b1, 1'b0, "R4 write set");
        // R5: memory changed since fetch (bit 9 and bit 6 set by another agent)
        txn(32'h1000_0009, 64'h0000_0000_0000_9001, 64'h0000_0000_0000_9241, 2'd0, 1'b1, 1'b0, 1'b0, "R5 concurrent");
        // R5: software cleared bit 1 in memory; block must not restore or clear others
        txn(32'h1000_000A, 64'h8000_0000_0000_A003, 64'h8000_0000_0000_A001, 2'd0, 1'b1, 1'b1, 1'b0, "R5 sw clear");
        // R6: pointer entries in three-level mode
        txn(32'h1000_000B, 64'h0000_0000_0000_B001, 64'h0000_0000_0000_B001, 2'd2, 1'b0, 1'b1, 1'b1, "R6 ptr present");
        txn(32'h1000_000C, 64'h0000_0000_0000_C000, 64'h0000_0000_0000_C000, 2'd2, 1'b0, 1'b0, 1'b1, "R6 ptr absent");
        // R6: three-level mode but level 1 updates normally; level 2 without mode updates
        txn(32'h1000_000D, 64'h0000_0000_0000_D001, 64'h0000_0000_0000_D001, 2'd1, 1'b0, 1'b0, 1'b1, "R6 mode lvl1");
        txn(32'h1000_000E, 64'h0000_0000_0000_E001, 64'h0000_0000_0000_E001, 2'd2, 1'b0, 1'b0, 1'b0, "R6 no mode lvl2");
        // R7: non-present entries
        txn(32'h1000_000F, 64'h0000_0000_0000_F000, 64'h0000_0000_0000_F000, 2'd0, 1'b1, 1'b1, 1'b0, "R7 absent leaf");
        txn(32'h1000_0000, 64'h0000_0000_0000_0040, 64'h0000_0000_0000_0040, 2'd3, 1'b0, 1'b0, 1'b1, "R7 absent lvl3");

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [63:0] e, m;
            logic [1:0] lv;
            logic lf;
            e  = {$urandom, $urandom};
            m  = ($urandom_range(0, 3) == 0) ? (e ^ (64'($urandom) & 64'h0000_0000_0000_0262)) : e;
            lv = 2'($urandom_range(0, 3));
            lf = (lv == 2'd0) ? 1'b1 : 1'($urandom_range(0, 1));
            txn({$urandom} , e, m, lv, lf, 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), "R1 R2 R5 random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule